// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block sits beside one port of a bus bridge and classifies each I/O or memory request address. It reports whether the request belongs on the far (downstream) side, or whether it must travel toward the host (upstream). The decision uses three address windows: an I/O window, a 32-bit memory window and a 64-bit prefetchable memory window. Each window is bounded by a base and a limit value. Two optional address qualifiers also take part. The ISA mode removes part of the I/O space. The display-compatibility mode adds legacy display I/O and frame-buffer addresses.

Software or a configuration block holds the window registers, and their values arrive here as plain inputs. A request is presented with a valid strobe, a kind code, the lower address DWORD and, for dual-address cycles, the upper DWORD. The verdict appears registered one clock later. The block does no queuing and no bus handshaking.

Top module: `addr_win_decoder`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted request, valid_o, fwd_down_o and fwd_up_o are all 0.
- R2: The verdict is registered. valid_o in cycle n+1 equals req_valid_i in cycle n. When valid_o is 0, fwd_down_o and fwd_up_o are both 0.
- R3: For kind 1 (I/O), the address is inside the I/O window when io_base_i <= addr_lo_i[31:12] <= io_limit_i. Such an address is forwarded downstream only if io_en_i is 1.
- R4: For kind 2 (single-address memory), the address is inside the memory window when mem_base_i <= addr_lo_i[31:20] <= mem_limit_i, which gives 1 MB granularity. Such an address is forwarded downstream only if mem_en_i is 1.
- R5: The prefetchable window compares the 64-bit address {upper, lower}[63:20] against the 44-bit pf_base_i and pf_limit_i. A single-address request uses 0 for the upper DWORD. A hit is forwarded downstream when mem_en_i is 1.
- R6: Any window whose base is greater than its limit matches no address. For the prefetchable window this includes the case where the difference lies only in the upper 32 bits.
- R7: A kind 3 (dual-address memory) request is forwarded downstream only on a prefetchable-window hit. The memory window and display ranges never claim it.
- R8: With isa_mode_i at 1, an I/O address that is in the window, has addr_lo_i[31:16] = 0 and has addr_lo_i[9:8] not equal to 0 is not forwarded downstream.
- R9: With vga_mode_i at 1, an I/O address with addr_lo_i[31:16] = 0 is claimed downstream when addr_lo_i[9:0] lies in 0x3B0–0x3BB or 0x3C0–0x3DF. Bits 15:10 are ignored. This claim overrides R8 and does not need the window.
- R10: With vga_mode_i at 1, a kind 2 address in 0x000A0000–0x000BFFFF is claimed downstream.
- R11: A valid request of kind 1–3 that is not forwarded downstream goes upstream only if master_en_i is 1.
- R12: fwd_down_o and fwd_up_o are never both 1. A kind 0 request sets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 none, 1 I/O, 2 memory, 3 dual-address memory |
| addr_lo_i | input | 32 | Lower address DWORD |
| addr_hi_i | input | 32 | Upper address DWORD (kind 3 only) |
| io_base_i | input | 20 | I/O window base, address bits 31:12 |
| io_limit_i | input | 20 | I/O window limit, address bits 31:12 |
| mem_base_i | input | 12 | Memory window base, address bits 31:20 |
| mem_limit_i | input | 12 | Memory window limit, address bits 31:20 |
| pf_base_i | input | 44 | Prefetchable base, address bits 63:20 |
| pf_limit_i | input | 44 | Prefetchable limit, address bits 63:20 |
| io_en_i | input | 1 | Allows I/O downstream |
| mem_en_i | input | 1 | Allows memory downstream |
| master_en_i | input | 1 | Allows upstream |
| isa_mode_i | input | 1 | ISA suppression qualifier |
| vga_mode_i | input | 1 | Display-compatibility qualifier |
| valid_o | output | 1 | Verdict present |
| fwd_down_o | output | 1 | Forward downstream |
| fwd_up_o | output | 1 | Forward upstream |

## Verification
Two functions can apply to the same I/O address in one cycle: ISA suppression and the display-compatibility alias. The bench provokes this with address 0x13C0, which lies inside the I/O window with both qualifiers set. It judges the outcome by requiring a downstream verdict, because the alias must win. The memory window and the prefetchable window can also both cover an address on a dual-address request. The bench places a dual-address request at an address inside the memory window and requires it to go upstream.

// File: rtl/addr_win_pkg.sv
`timescale 1ns/1ps
package addr_win_pkg;
  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_IO       = 2'd1,
    KIND_MEM      = 2'd2,
    KIND_MEM_DUAL = 2'd3
  } txn_kind_e;

  localparam int unsigned ISA_SPAN_BITS = 16; // first 64 KB of I/O space
endpackage

// File: rtl/awd_range_cmp.sv
`timescale 1ns/1ps
module awd_range_cmp #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  // base > limit yields no hit at all
  assign hit_o = (val_i >= base_i) && (val_i <= limit_i);
endmodule

// File: rtl/awd_io_decode.sv
`timescale 1ns/1ps
module awd_io_decode
  import addr_win_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned IO_GRAN = 12,
  localparam int unsigned FW     = AW - IO_GRAN
) (
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] limit_i,
  input  logic          isa_mode_i,
  input  logic          vga_mode_i,
  output logic          win_hit_o,
  output logic          isa_block_o,
  output logic          vga_hit_o
);
  logic       low64k;
  logic [9:0] off;

  awd_range_cmp #(.W(FW)) u_io_cmp (
    .val_i  (addr_i[AW-1:IO_GRAN]),
    .base_i (base_i),
    .limit_i(limit_i),
    .hit_o  (win_hit_o)
  );

  assign low64k = (addr_i[AW-1:ISA_SPAN_BITS] == '0);
  assign off    = addr_i[9:0];

  // upper 768 bytes of each 1 KB block stay on the ISA side
  assign isa_block_o = isa_mode_i && win_hit_o && low64k && (off[9:8] != 2'b00);

  // legacy display ports, aliased every 1 KB
  assign vga_hit_o = vga_mode_i && low64k &&
                     (((off >= 10'h3B0) && (off <= 10'h3BB)) ||
                      ((off >= 10'h3C0) && (off <= 10'h3DF)));
endmodule

// File: rtl/awd_mem_decode.sv
`timescale 1ns/1ps
module awd_mem_decode #(
  parameter int unsigned AW       = 32,
  parameter int unsigned MEM_GRAN = 20,
  localparam int unsigned MW      = AW - MEM_GRAN,
  localparam int unsigned PW      = 2*AW - MEM_GRAN
) (
  input  logic [AW-1:0] addr_lo_i,
  input  logic [AW-1:0] addr_hi_i,
  input  logic          dual_i,
  input  logic [MW-1:0] mem_base_i,
  input  logic [MW-1:0] mem_limit_i,
  input  logic [PW-1:0] pf_base_i,
  input  logic [PW-1:0] pf_limit_i,
  input  logic          vga_mode_i,
  output logic          mem_hit_o,
  output logic          pf_hit_o,
  output logic          vga_hit_o
);
  localparam logic [AW-1:0] VGA_LO = AW'(32'h000A_0000);
  localparam logic [AW-1:0] VGA_HI = AW'(32'h000B_FFFF);

  logic [2*AW-1:0] full_addr;
  logic            mem_raw;

  assign full_addr = {(dual_i ? addr_hi_i : '0), addr_lo_i};

  awd_range_cmp #(.W(MW)) u_mem_cmp (
    .val_i  (addr_lo_i[AW-1:MEM_GRAN]),
    .base_i (mem_base_i),
    .limit_i(mem_limit_i),
    .hit_o  (mem_raw)
  );

  awd_range_cmp #(.W(PW)) u_pf_cmp (
    .val_i  (full_addr[2*AW-1:MEM_GRAN]),
    .base_i (pf_base_i),
    .limit_i(pf_limit_i),
    .hit_o  (pf_hit_o)
  );

  assign mem_hit_o = mem_raw && !dual_i;
  assign vga_hit_o = vga_mode_i && !dual_i &&
                     (addr_lo_i >= VGA_LO) && (addr_lo_i <= VGA_HI);
endmodule

// File: rtl/addr_win_decoder.sv
`timescale 1ns/1ps
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned IO_GRAN  = 12,
  parameter int unsigned MEM_GRAN = 20,
  localparam int unsigned IW      = AW - IO_GRAN,
  localparam int unsigned MW      = AW - MEM_GRAN,
  localparam int unsigned PW      = 2*AW - MEM_GRAN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_kind_i,
  input  logic [AW-1:0] addr_lo_i,
  input  logic [AW-1:0] addr_hi_i,
  input  logic [IW-1:0] io_base_i,
  input  logic [IW-1:0] io_limit_i,
  input  logic [MW-1:0] mem_base_i,
  input  logic [MW-1:0] mem_limit_i,
  input  logic [PW-1:0] pf_base_i,
  input  logic [PW-1:0] pf_limit_i,
  input  logic          io_en_i,
  input  logic          mem_en_i,
  input  logic          master_en_i,
  input  logic          isa_mode_i,
  input  logic          vga_mode_i,
  output logic          valid_o,
  output logic          fwd_down_o,
  output logic          fwd_up_o
);
  txn_kind_e kind;
  logic is_io, is_mem, is_dual;
  logic io_win, io_isa_blk, io_vga;
  logic mem_win, pf_win, mem_vga;
  logic down_d, up_d;

  assign kind    = txn_kind_e'(req_kind_i);
  assign is_io   = (kind == KIND_IO);
  assign is_dual = (kind == KIND_MEM_DUAL);
  assign is_mem  = (kind == KIND_MEM) || is_dual;

  awd_io_decode #(.AW(AW), .IO_GRAN(IO_GRAN)) u_io (
    .addr_i     (addr_lo_i),
    .base_i     (io_base_i),
    .limit_i    (io_limit_i),
    .isa_mode_i (isa_mode_i),
    .vga_mode_i (vga_mode_i),
    .win_hit_o  (io_win),
    .isa_block_o(io_isa_blk),
    .vga_hit_o  (io_vga)
  );

  awd_mem_decode #(.AW(AW), .MEM_GRAN(MEM_GRAN)) u_mem (
    .addr_lo_i  (addr_lo_i),
    .addr_hi_i  (addr_hi_i),
    .dual_i     (is_dual),
    .mem_base_i (mem_base_i),
    .mem_limit_i(mem_limit_i),
    .pf_base_i  (pf_base_i),
    .pf_limit_i (pf_limit_i),
    .vga_mode_i (vga_mode_i),
    .mem_hit_o  (mem_win),
    .pf_hit_o   (pf_win),
    .vga_hit_o  (mem_vga)
  );

  always_comb begin
    down_d = 1'b0;
    if (is_io)
      down_d = io_en_i && (io_vga || (io_win && !io_isa_blk));
    else if (is_mem)
      down_d = mem_en_i && (mem_win || pf_win || mem_vga);
    up_d = (is_io || is_mem) && !down_d && master_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      fwd_down_o <= 1'b0;
      fwd_up_o   <= 1'b0;
    end else begin
      valid_o    <= req_valid_i;
      fwd_down_o <= req_valid_i && down_d;
      fwd_up_o   <= req_valid_i && up_d;
    end
  end

  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_down_o && fwd_up_o));
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!fwd_down_o && !fwd_up_o));
  a_r11_up_needs_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !master_en_i) |=> !fwd_up_o);
  a_r3_io_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_io && !io_en_i) |=> !fwd_down_o);
  a_r7_dual_pf_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_dual && !pf_win) |=> !fwd_down_o);
endmodule

// File: tb/addr_win_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_win_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = 2'd0;
  logic [31:0] addr_lo_i = '0, addr_hi_i = '0;
  logic [19:0] io_base_i, io_limit_i;
  logic [11:0] mem_base_i, mem_limit_i;
  logic [43:0] pf_base_i, pf_limit_i;
  logic        io_en_i, mem_en_i, master_en_i, isa_mode_i, vga_mode_i;
  logic        valid_o, fwd_down_o, fwd_up_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  addr_win_decoder dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_kind_i, .addr_lo_i, .addr_hi_i,
    .io_base_i, .io_limit_i, .mem_base_i, .mem_limit_i, .pf_base_i, .pf_limit_i,
    .io_en_i, .mem_en_i, .master_en_i, .isa_mode_i, .vga_mode_i,
    .valid_o, .fwd_down_o, .fwd_up_o
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] hi;
    logic [31:0] lo;
    logic        isa;
    logic        vga;
    logic        dn;
    logic        up;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 window low edge
    '{2'd1, 32'h0, 32'h0000_2FFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 window high edge
    '{2'd1, 32'h0, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 just above
    '{2'd1, 32'h0, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 just below
    '{2'd1, 32'h0, 32'h0000_1100, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 suppressed
    '{2'd1, 32'h0, 32'h0000_1004, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 low 256 bytes kept
    '{2'd1, 32'h0, 32'h0000_13C0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 overrides R8
    '{2'd1, 32'h0, 32'h0000_53B4, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 alias outside window
    '{2'd1, 32'h0, 32'h0001_03C0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 needs [31:16]=0
    '{2'd2, 32'h0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 low edge
    '{2'd2, 32'h0, 32'h80FF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 high edge
    '{2'd2, 32'h0, 32'h8100_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 above
    '{2'd2, 32'h0, 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 frame buffer
    '{2'd2, 32'h0, 32'h000B_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 mode off
    '{2'd3, 32'h1, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 dual hit
    '{2'd3, 32'h1, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 dual above
    '{2'd3, 32'h0, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 mem window ignored
    '{2'd0, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}  // R12 kind none
  };

  task automatic check(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", rq, act, exp);
    end
  endtask

  task automatic defaults();
    io_base_i = 20'h00001; io_limit_i = 20'h00002;
    mem_base_i = 12'h800;  mem_limit_i = 12'h80F;
    pf_base_i = 44'h0000_0001_000; pf_limit_i = 44'h0000_0001_00F;
    io_en_i = 1; mem_en_i = 1; master_en_i = 1; isa_mode_i = 0; vga_mode_i = 0;
  endtask

  task automatic run(input logic [1:0] k, input logic [31:0] hi, input logic [31:0] lo,
                     input string rq, input logic dn, input logic up);
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = k; addr_hi_i = hi; addr_lo_i = lo;
    @(negedge clk_i);
    req_valid_i = 0;
    check({rq, " valid"}, valid_o, 1'b1);
    check({rq, " down"}, fwd_down_o, dn);
    check({rq, " up"}, fwd_up_o, up);
  endtask

  initial begin
    #200000ns;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    defaults();
    req_valid_i = 1; req_kind_i = 2'd1; addr_lo_i = 32'h1000;
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", valid_o, 1'b0);
    check("R1 reset down", fwd_down_o, 1'b0);
    check("R1 reset up", fwd_up_o, 1'b0);
    req_valid_i = 0;
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 post-reset valid", valid_o, 1'b0);
    check("R2 idle down", fwd_down_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      isa_mode_i = VECS[i].isa; vga_mode_i = VECS[i].vga;
      run(VECS[i].kind, VECS[i].hi, VECS[i].lo, $sformatf("R%0d vec %0d", VECS[i].rq, i),
          VECS[i].dn, VECS[i].up);
    end
    defaults();

    // R2: verdict drops one cycle after the strobe
    @(negedge clk_i);
    check("R2 valid cleared", valid_o, 1'b0);
    check("R2 down cleared", fwd_down_o, 1'b0);

    // R3 / R11: enables
    io_en_i = 0;
    run(2'd1, 32'h0, 32'h1000, "R3 io_en off", 1'b0, 1'b1);
    io_en_i = 1; mem_en_i = 0;
    run(2'd2, 32'h0, 32'h8000_0000, "R4 mem_en off", 1'b0, 1'b1);
    mem_en_i = 1; master_en_i = 0;
    run(2'd1, 32'h0, 32'h5000, "R11 master off", 1'b0, 1'b0);
    master_en_i = 1;

    // R6: base above limit
    io_base_i = 20'h00002; io_limit_i = 20'h00001;
    run(2'd1, 32'h0, 32'h1000, "R6 io off", 1'b0, 1'b1);
    run(2'd1, 32'h0, 32'h2000, "R6 io off hi", 1'b0, 1'b1);
    mem_base_i = 12'h810; mem_limit_i = 12'h80F;
    run(2'd2, 32'h0, 32'h8100_0000, "R6 mem off", 1'b0, 1'b1);
    defaults();

    // R5: comparison across upper DWORD
    pf_base_i = 44'h0000_0001_800; pf_limit_i = 44'h0000_0002_000;
    run(2'd3, 32'h1, 32'h0000_0000, "R5 below in low bits", 1'b0, 1'b1);
    run(2'd3, 32'h1, 32'h9000_0000, "R5 inside", 1'b1, 1'b0);
    run(2'd3, 32'h2, 32'h0000_0000, "R5 limit edge", 1'b1, 1'b0);
    run(2'd3, 32'h2, 32'h0010_0000, "R5 above", 1'b0, 1'b1);
    pf_base_i = 44'h0000_0002_000; pf_limit_i = 44'h0000_0001_FFF;
    run(2'd3, 32'h1, 32'hFFF0_0000, "R6 pf off by upper bits", 1'b0, 1'b1);
    // R5: single-address request against a low prefetchable window
    pf_base_i = 44'h0000_0000_900; pf_limit_i = 44'h0000_0000_90F;
    run(2'd2, 32'hFFFF_FFFF, 32'h9000_0000, "R5 single addr hi ignored", 1'b1, 1'b0);
    defaults();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule